// File: doc/BRIEF.md
# Boundary-Scan TAP Controller

This block is the test access port of a chip. A serial test clock, a mode-select line, a serial data input and an active-low asynchronous test reset drive a sixteen-state controller. That controller steers bits through a 4-bit instruction register or through one of three data registers: a 1-bit bypass stage, an identification register, and a boundary chain of configurable length. The chain captures the pad inputs and holds update values that can replace the core's outputs at the pads.

The latched instruction is decoded into a data-register select and four control outputs: pad override, pad tri-state, functional reset of the core, and the enable of an on-chip debug controller. The debug controller is outside this block. Serial output changes only on the falling test-clock edge, and its enable is high only while a shift state is active.

One factory instruction latches permanently. After it is loaded, only the reset pin can replace it. Opcodes that the map does not use fall back to bypass.

Top module: `scan_tap`

## Requirements
- R1: While `trst_n` is low the controller is in Test-Logic-Reset, the instruction is IDCODE (0001), every boundary update cell is 0, and `tdo`, `tdo_en`, `out_hiz`, `func_rst` and `dbg_en` are 0 with `pin_out` equal to `core_out`.
- R2: Capture-IR loads 4'b0001 into the instruction shift stage. Shift-IR moves bits least significant first from `tdi` towards `tdo`, and Update-IR latches the shifted value.
- R3: Opcode 0001 selects the identification register. Capture-DR loads `ID_CODE`, whose bit 0 is 1, and Shift-DR sends it out least significant bit first.
- R4: Opcodes 1111, 1010, 1011, 0101, 0110, 0111, 1000, 1101 and 1110 select the 1-bit bypass register, which captures 0, delays `tdi` by one shift, and raises no control output.
- R5: Opcode 0010 selects the boundary chain. Capture-DR loads `bnd_in` (cell i from bit i, cell 0 nearest `tdo`), and Update-DR copies the chain into the update cells. `pin_out` stays equal to `core_out` and `func_rst` stays 0.
- R6: Opcode 0000 selects the boundary chain, drives the update cells onto `pin_out` and raises `func_rst`.
- R7: Opcode 1001 selects bypass and raises `out_hiz` and `func_rst`. `pin_out` stays equal to `core_out`.
- R8: Opcode 1100 selects bypass, drives the held update cells onto `pin_out` and raises `func_rst`.
- R9: Opcode 0011 selects bypass and raises `dbg_en` only.
- R10: Five consecutive rising `tck` edges with `tms` high reach Test-Logic-Reset from any state, and the next edge in that state reloads IDCODE.
- R11: `tdo` and `tdo_en` change only on falling `tck` edges, and `tdo_en` is 1 exactly while the controller is in Shift-DR or Shift-IR.
- R12: Once opcode 0100 is latched by Update-IR, later Update-IR and Test-Logic-Reset leave it in place. It acts as bypass with no control output until `trst_n` goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| tdo | output | 1 | Serial data out, changes on falling `tck` |
| tdo_en | output | 1 | High while serial output is valid (shift states) |
| bnd_in | input | BND_LEN | Pad input values captured by the boundary chain |
| core_out | input | BND_LEN | Functional output values from the core |
| pin_out | output | BND_LEN | Values presented to the pads |
| out_hiz | output | 1 | Tri-state request for all outputs |
| func_rst | output | 1 | Functional reset of the core |
| dbg_en | output | 1 | Enable for the on-chip debug controller |

## Verification
A new instruction governs the control outputs from the rising edge that leaves Update-IR. The bench therefore samples them one falling edge after that transition, with one Run-Test/Idle cycle placed in between. A serial bit captured or shifted on a rising edge appears on `tdo` at the following falling edge. Each shift cycle reads `tdo` just after a falling edge and only then drives the next `tms`/`tdi` pair, so scan N returns N bits with no skew. Pad values from an Update-DR are read after the same one idle cycle. A TMS-driven reset is given five high edges plus one idle edge before the identification register is read back.

// File: rtl/tap_pkg.sv
package tap_pkg;

   localparam int IR_W = 4;

   typedef enum logic [3:0] {
      ST_RESET, ST_IDLE,
      ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
      ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
   } tap_state_t;

   localparam logic [IR_W-1:0] OP_EXTEST  = 4'b0000;
   localparam logic [IR_W-1:0] OP_IDCODE  = 4'b0001;
   localparam logic [IR_W-1:0] OP_SAMPLE  = 4'b0010;
   localparam logic [IR_W-1:0] OP_DBGEN   = 4'b0011;
   localparam logic [IR_W-1:0] OP_LOCK    = 4'b0100;
   localparam logic [IR_W-1:0] OP_HIGHZ   = 4'b1001;
   localparam logic [IR_W-1:0] OP_CLAMP   = 4'b1100;
   localparam logic [IR_W-1:0] OP_BYPASS  = 4'b1111;
   localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

   typedef enum logic [1:0] {SEL_BYP, SEL_ID, SEL_BND} dr_sel_t;

   typedef struct packed {
      dr_sel_t sel;
      logic    override;
      logic    hiz;
      logic    frst;
      logic    dbg;
   } tap_ctl_t;

   function automatic tap_ctl_t decode_op(input logic [IR_W-1:0] op);
      tap_ctl_t c;
      c = '{sel: SEL_BYP, override: 1'b0, hiz: 1'b0, frst: 1'b0, dbg: 1'b0};
      case (op)
         OP_EXTEST: begin c.sel = SEL_BND; c.override = 1'b1; c.frst = 1'b1; end
         OP_IDCODE: c.sel = SEL_ID;
         OP_SAMPLE: c.sel = SEL_BND;
         OP_DBGEN:  c.dbg = 1'b1;
         OP_HIGHZ:  begin c.hiz = 1'b1; c.frst = 1'b1; end
         OP_CLAMP:  begin c.override = 1'b1; c.frst = 1'b1; end
         default:   c.sel = SEL_BYP;
      endcase
      return c;
   endfunction

   function automatic tap_state_t next_state(input tap_state_t s, input logic m);
      tap_state_t n;
      case (s)
         ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
         ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
         ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
         ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
         ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
         ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
         ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
         ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
         ST_SEL_IR: n = m ? ST_RESET  : ST_CAP_IR;
         ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
         ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
         ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
         ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
         ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
         default:   n = m ? ST_SEL_DR : ST_IDLE;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
   import tap_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   output tap_state_t state
);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) state <= ST_RESET;
      else         state <= next_state(state, tms);
   end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
   import tap_pkg::*;
(
   input  logic            tck,
   input  logic            trst_n,
   input  tap_state_t      state,
   input  logic            tdi,
   output logic [IR_W-1:0] ir,
   output logic            ir_so,
   output logic            sticky
);

   logic [IR_W-1:0] sr;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         sr     <= '0;
         ir     <= OP_IDCODE;
         sticky <= 1'b0;
      end else begin
         if (state == ST_CAP_IR)     sr <= IR_CAPTURE;
         else if (state == ST_SH_IR) sr <= {tdi, sr[IR_W-1:1]};
         if (!sticky) begin
            if (state == ST_RESET) begin
               ir <= OP_IDCODE;
            end else if (state == ST_UPD_IR) begin
               ir     <= sr;
               sticky <= (sr == OP_LOCK);
            end
         end
      end
   end

   assign ir_so = sr[0];

endmodule

// File: rtl/tap_bsr.sv
module tap_bsr
   import tap_pkg::*;
#(
   parameter int LEN = 8
) (
   input  logic           tck,
   input  logic           trst_n,
   input  tap_state_t     state,
   input  logic           sel,
   input  logic           tdi,
   input  logic [LEN-1:0] pin_in,
   output logic [LEN-1:0] upd,
   output logic           so
);

   logic [LEN:0] chain;

   assign chain[LEN] = tdi;

   for (genvar i = 0; i < LEN; i++) begin : g_cell
      logic cap_q;
      logic upd_q;
      always_ff @(posedge tck or negedge trst_n) begin
         if (!trst_n) begin
            cap_q <= 1'b0;
            upd_q <= 1'b0;
         end else if (sel) begin
            case (state)
               ST_CAP_DR: cap_q <= pin_in[i];
               ST_SH_DR:  cap_q <= chain[i+1];
               ST_UPD_DR: upd_q <= cap_q;
               default:   ;
            endcase
         end
      end
      assign chain[i] = cap_q;
      assign upd[i]   = upd_q;
   end

   assign so = chain[0];

endmodule

// File: rtl/scan_tap.sv
module scan_tap
   import tap_pkg::*;
#(
   parameter int               BND_LEN = 8,
   parameter int               ID_W    = 32,
   parameter logic [ID_W-1:0]  ID_CODE = 32'h0B5E_A0C3
) (
   input  logic               tck,
   input  logic               trst_n,
   input  logic               tms,
   input  logic               tdi,
   output logic               tdo,
   output logic               tdo_en,
   input  logic [BND_LEN-1:0] bnd_in,
   input  logic [BND_LEN-1:0] core_out,
   output logic [BND_LEN-1:0] pin_out,
   output logic               out_hiz,
   output logic               func_rst,
   output logic               dbg_en
);

   if (BND_LEN < 1) begin : g_bad_len
      $error("scan_tap: BND_LEN must be at least 1");
   end
   if (ID_W < 2) begin : g_bad_idw
      $error("scan_tap: ID_W must be at least 2");
   end
   if (ID_CODE[0] != 1'b1) begin : g_bad_id
      $error("scan_tap: ID_CODE bit 0 must be 1");
   end

   tap_state_t          state;
   logic [IR_W-1:0]     ir;
   logic                ir_so;
   logic                sticky;
   tap_ctl_t            ctl;
   logic [ID_W-1:0]     id_sr;
   logic                byp;
   logic [BND_LEN-1:0]  bnd_upd;
   logic                bnd_so;
   logic                dr_so;

   tap_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .state(state));

   tap_ir u_ir (
      .tck(tck), .trst_n(trst_n), .state(state), .tdi(tdi),
      .ir(ir), .ir_so(ir_so), .sticky(sticky)
   );

   assign ctl = decode_op(ir);

   tap_bsr #(.LEN(BND_LEN)) u_bsr (
      .tck(tck), .trst_n(trst_n), .state(state), .sel(ctl.sel == SEL_BND),
      .tdi(tdi), .pin_in(bnd_in), .upd(bnd_upd), .so(bnd_so)
   );

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         id_sr <= '0;
         byp   <= 1'b0;
      end else begin
         if (state == ST_CAP_DR) begin
            byp <= 1'b0;
            if (ctl.sel == SEL_ID) id_sr <= ID_CODE;
         end else if (state == ST_SH_DR) begin
            byp <= tdi;
            if (ctl.sel == SEL_ID) id_sr <= {tdi, id_sr[ID_W-1:1]};
         end
      end
   end

   always_comb begin
      case (ctl.sel)
         SEL_ID:  dr_so = id_sr[0];
         SEL_BND: dr_so = bnd_so;
         default: dr_so = byp;
      endcase
   end

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo    <= 1'b0;
         tdo_en <= 1'b0;
      end else begin
         tdo_en <= (state == ST_SH_DR) || (state == ST_SH_IR);
         tdo    <= (state == ST_SH_IR) ? ir_so : dr_so;
      end
   end

   assign pin_out  = ctl.override ? bnd_upd : core_out;
   assign out_hiz  = ctl.hiz;
   assign func_rst = ctl.frst;
   assign dbg_en   = ctl.dbg;

endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk #(
   parameter int N = 8
) (
   input logic         tck,
   input logic         trst_n,
   input logic         tms,
   input logic         tdo_en,
   input logic [3:0]   state,
   input logic [N-1:0] pin_out,
   input logic [N-1:0] core_out,
   input logic         out_hiz,
   input logic         func_rst,
   input logic         dbg_en,
   input logic         sticky
);

   localparam logic [3:0] S_RESET = 4'd0;
   localparam logic [3:0] S_SHDR  = 4'd4;
   localparam logic [3:0] S_SHIR  = 4'd11;

   logic [2:0] high_cnt;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)      high_cnt <= '0;
      else if (!tms)    high_cnt <= '0;
      else if (high_cnt != 3'd7) high_cnt <= high_cnt + 3'd1;
   end

   // R11: output enable set on the previous falling edge matches the shift state
   assert_tdo_window_R11: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_en == ((state == S_SHDR) || (state == S_SHIR)));

   // R10: five high TMS edges always land in Test-Logic-Reset
   assert_tms_reset_R10: assert property (@(posedge tck) disable iff (!trst_n)
      (high_cnt >= 3'd5) |-> (state == S_RESET));

   // R7: tri-state request always comes with functional reset
   assert_hiz_reset_R7: assert property (@(posedge tck) disable iff (!trst_n)
      out_hiz |-> func_rst);

   // R6: pads only depart from the core while the core is held in reset
   assert_override_reset_R6: assert property (@(posedge tck) disable iff (!trst_n)
      (pin_out != core_out) |-> func_rst);

   // R9: debug enable excludes the test-mode controls
   assert_dbg_alone_R9: assert property (@(posedge tck) disable iff (!trst_n)
      dbg_en |-> (!func_rst && !out_hiz));

   // R12: the latched factory instruction keeps every control output low
   assert_sticky_quiet_R12: assert property (@(posedge tck) disable iff (!trst_n)
      sticky |-> (!func_rst && !out_hiz && !dbg_en && (pin_out == core_out)));

endmodule

bind scan_tap scan_tap_chk #(.N(BND_LEN)) u_chk (
   .tck(tck), .trst_n(trst_n), .tms(tms), .tdo_en(tdo_en), .state(state),
   .pin_out(pin_out), .core_out(core_out), .out_hiz(out_hiz),
   .func_rst(func_rst), .dbg_en(dbg_en), .sticky(sticky)
);

// File: tb/scan_tap_test.sv
`timescale 1ns/100ps
module scan_tap_test;

   localparam int          N    = 8;
   localparam logic [31:0] IDC  = 32'h0B5E_A0C3;

   logic         tck = 1'b0;
   logic         trst_n = 1'b0;
   logic         tms = 1'b1;
   logic         tdi = 1'b0;
   logic         tdo, tdo_en;
   logic [N-1:0] bnd_in = '0;
   logic [N-1:0] core_out = '0;
   logic [N-1:0] pin_out;
   logic         out_hiz, func_rst, dbg_en;

   int total = 0;
   int bad   = 0;
   bit done  = 0;
   logic last_en;
   logic [N-1:0] upd_m;

   always #2.5 tck = ~tck;

   scan_tap #(.BND_LEN(N), .ID_W(32), .ID_CODE(IDC)) uut (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
      .bnd_in(bnd_in), .core_out(core_out), .pin_out(pin_out),
      .out_hiz(out_hiz), .func_rst(func_rst), .dbg_en(dbg_en)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input logic m, input logic d, output logic o);
      @(negedge tck);
      #1;
      o       = tdo;
      last_en = tdo_en;
      tms     = m;
      tdi     = d;
   endtask

   task automatic idle();
      logic o;
      tick(1'b0, 1'b0, o);
   endtask

   task automatic scan_ir(input logic [3:0] op, output logic [3:0] got);
      logic o;
      tick(1'b1, 1'b0, o); tick(1'b1, 1'b0, o); tick(1'b0, 1'b0, o); tick(1'b0, 1'b0, o);
      for (int i = 0; i < 4; i++) tick(i == 3, op[i], got[i]);
      tick(1'b1, 1'b0, o); tick(1'b0, 1'b0, o);
      idle();
   endtask

   task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
      logic o;
      dout = '0;
      tick(1'b1, 1'b0, o); tick(1'b0, 1'b0, o); tick(1'b0, 1'b0, o);
      for (int i = 0; i < n; i++) begin
         tick(i == n - 1, din[i], o);
         dout[i] = o;
         if (i == 0) chk("R11 tdo_en in Shift-DR", 64'(last_en), 64'd1);
      end
      tick(1'b1, 1'b0, o); tick(1'b0, 1'b0, o);
      idle();
   endtask

   function automatic int kind_of(input logic [3:0] op);
      if (op == 4'b0001) return 1;
      if (op == 4'b0000 || op == 4'b0010) return 2;
      return 0;
   endfunction

   function automatic string req_of(input logic [3:0] op);
      case (op)
         4'b0000: return "R6 EXTEST";
         4'b0001: return "R3 IDCODE";
         4'b0010: return "R5 SAMPLE";
         4'b0011: return "R9 debug";
         4'b1001: return "R7 HIGHZ";
         4'b1100: return "R8 CLAMP";
         default: return "R4 bypass";
      endcase
   endfunction

   function automatic logic [N-1:0] exp_pins(input logic [3:0] op);
      return (op == 4'b0000 || op == 4'b1100) ? upd_m : core_out;
   endfunction

   task automatic check_ctl(input logic [3:0] op);
      string r;
      r = req_of(op);
      chk({r, " func_rst"}, 64'(func_rst), 64'(op == 4'b0000 || op == 4'b1001 || op == 4'b1100));
      chk({r, " out_hiz"},  64'(out_hiz),  64'(op == 4'b1001));
      chk({r, " dbg_en"},   64'(dbg_en),   64'(op == 4'b0011));
      chk({r, " pin_out"},  64'(pin_out),  64'(exp_pins(op)));
   endtask

   task automatic check_bypass(input string r);
      logic [63:0] din, dout;
      din = {32'h0, $urandom} & 64'h1FF;
      scan_dr(N + 1, din, dout);
      chk(r, dout & 64'h1FF, {din[62:0], 1'b0} & 64'h1FF);
   endtask

   task automatic pulse_trst();
      @(negedge tck);
      trst_n = 1'b0;
      tms    = 1'b1;
      #1;
      trst_n = 1'b1;
      upd_m  = '0;
      tms    = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge tck);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [3:0]  g, op;
      logic [63:0] dout, din;
      logic        o;
      void'($urandom(32'd20250611));
      upd_m    = '0;
      core_out = 8'hA5;
      repeat (3) @(posedge tck);
      #1;
      // R1: reset state
      chk("R1 tdo", 64'(tdo), 64'd0);
      chk("R1 tdo_en", 64'(tdo_en), 64'd0);
      check_ctl(4'b0001);
      @(negedge tck);
      #1;
      trst_n = 1'b1;
      tms    = 1'b0;
      idle();
      chk("R11 tdo_en idle", 64'(last_en), 64'd0);
      // R1/R3: IDCODE after reset
      scan_dr(32, 64'h0, dout);
      chk("R3 IDCODE value", dout, 64'(IDC));
      chk("R3 IDCODE lsb", 64'(dout[0]), 64'd1);

      // random mix, R2 checked on every IR scan
      for (int it = 0; it < 40; it++) begin
         op = 4'($urandom_range(15));
         if (op == 4'b0100) op = 4'b1111;
         bnd_in   = N'($urandom);
         core_out = N'($urandom);
         scan_ir(op, g);
         chk("R2 capture-IR", 64'(g), 64'd1);
         check_ctl(op);
         case (kind_of(op))
            1: begin
               scan_dr(32, {32'h0, $urandom}, dout);
               chk("R3 IDCODE scan", dout, 64'(IDC));
            end
            2: begin
               din = {56'h0, 8'($urandom)};
               scan_dr(N, din, dout);
               chk({req_of(op), " capture"}, dout, 64'(bnd_in));
               upd_m = din[N-1:0];
               check_ctl(op);
            end
            default: check_bypass({req_of(op), " length"});
         endcase
      end

      // directed: preload then CLAMP then HIGHZ
      scan_ir(4'b0010, g);
      scan_dr(N, 64'h3C, dout);
      upd_m = 8'h3C;
      chk("R5 preload keeps pins", 64'(pin_out), 64'(core_out));
      scan_ir(4'b1100, g);
      check_ctl(4'b1100);
      check_bypass("R8 CLAMP bypass");
      check_ctl(4'b1100);
      scan_ir(4'b1001, g);
      check_ctl(4'b1001);

      // R10: TMS reset reloads IDCODE
      scan_ir(4'b1111, g);
      for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, o);
      idle();
      check_ctl(4'b0001);
      scan_dr(32, 64'h0, dout);
      chk("R10 IDCODE after TMS reset", dout, 64'(IDC));

      // R12: sticky factory instruction
      scan_ir(4'b0100, g);
      check_ctl(4'b0100);
      scan_ir(4'b0000, g);
      chk("R12 EXTEST ignored func_rst", 64'(func_rst), 64'd0);
      check_bypass("R12 still bypass after Update-IR");
      for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, o);
      idle();
      check_bypass("R12 still bypass after TMS reset");
      pulse_trst();
      idle();
      scan_dr(32, 64'h0, dout);
      chk("R12 TRST releases to IDCODE", dout, 64'(IDC));
      scan_ir(4'b0000, g);
      chk("R12 EXTEST accepted after TRST", 64'(func_rst), 64'd1);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule